// File: doc/BRIEF.md
# Source Alignment Shifter for Block Transfers

This block lines up source words with destination bit positions during a block transfer. It keeps the two most recent source words in a 32-bit buffer. It presents a 16-bit window of that buffer, offset by a 4-bit skew amount. A sequencer pulses `step` once for each word slot of a line, and `kind` tells the block which slot this is: an ordinary word, an extra priming fetch at the start of a line, or the final word of a line. The block answers on `fetch_req` with whether that slot needs a source read.

The fill direction follows the direction of the source walk. When the source address rises, or stays still, old data moves up and new words enter the low half. When the source address falls, old data moves down and new words enter the high half. Two flags in the configuration byte apply per line. One turns on a priming fetch. The other drops the read for the last word of a line. The buffer is cleared when a transfer begins and keeps its contents from one line to the next. In the combine modes that take no source data, the shifter is idle.

Top module: `skew_aligner`

## Requirements
- R1: A write with `cfg_wr` high stores `cfg_data & 8'hCF`, and `cfg_q` shows the stored byte from the next cycle on. Bit 7 is the prime-fetch flag, bit 6 is the no-final-fetch flag, and bits 3..0 are the skew.
- R2: `win` always equals bits 15..0 of the buffer shifted right by the skew held in `cfg_q[3:0]`.
- R3: With `dir_neg` low, an active step that fetches sets the buffer to {old low half, `src_word`}.
- R4: With `dir_neg` high, an active step that fetches sets the buffer to {`src_word`, old high half}.
- R5: A step with `kind` = 2'b01 (prime) while the prime-fetch flag is set raises `fetch_req`, shifts the buffer and loads `src_word`.
- R6: A prime step while the prime-fetch flag is clear has no effect on the buffer, and `fetch_req` is low.
- R7: A step with `kind` = 2'b10 (last) while the no-final-fetch flag is set holds `fetch_req` low and shifts zeros into the buffer in place of a new word. `kind` 2'b00 and 2'b11 are ordinary words, and they always fetch in source modes.
- R8: `xfer_start` clears the buffer to zero. Nothing else clears it, so the contents carry across line boundaries.
- R9: When `mode[1]` is 0 (modes 0 and 1), `fetch_req` is low and steps leave the buffer unchanged.
- R10: After reset, `cfg_q`, `win` and the buffer are zero.
- R11: `xfer_start` takes priority over a step in the same cycle, so the buffer becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_data | input | 8 | Configuration byte to write |
| cfg_q | output | 8 | Stored configuration byte |
| dir_neg | input | 1 | Source walks toward lower addresses |
| mode | input | 2 | Combine mode; source used when bit 1 is set |
| xfer_start | input | 1 | Start of transfer; clears buffer |
| step | input | 1 | Word slot strobe |
| kind | input | 2 | Slot type: 00 normal, 01 prime, 10 last, 11 normal |
| src_word | input | 16 | Fetched source word, valid on a fetching step |
| fetch_req | output | 1 | Current slot needs a source read |
| win | output | 16 | Aligned source window |

## Verification
The buffer is filled with distinct word patterns, in both fill directions and across several skew values. This separates a wrong shift direction from a wrong window offset or a half loaded into the wrong place. Lines are run with the prime flag on and off and with the final-fetch flag on and off. This shows whether each slot type fetches, shifts or does nothing. A second line without a restart, a step coinciding with a restart, and steps in the non-source modes check retention, clear priority and idleness.

// File: rtl/skew_aligner.sv
module skew_aligner #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [7:0]   cfg_data,
  output logic [7:0]   cfg_q,
  input  logic         dir_neg,
  input  logic [1:0]   mode,
  input  logic         xfer_start,
  input  logic         step,
  input  logic [1:0]   kind,
  input  logic [W-1:0] src_word,
  output logic         fetch_req,
  output logic [W-1:0] win
);
  localparam int BW = 2 * W;
  localparam int SW = $clog2(W);
  localparam logic [7:0] CFG_MASK = 8'hC0 | 8'((1 << SW) - 1);

  logic [BW-1:0] sbuf;
  logic [7:0]    cfg_r;

  wire          pre_en   = cfg_r[7];
  wire          nofin_en = cfg_r[6];
  wire [SW-1:0] sk       = cfg_r[SW-1:0];
  wire          use_src  = mode[1];
  wire          is_prime = (kind == 2'b01);
  wire          is_last  = (kind == 2'b10);
  wire          skip     = is_prime & ~pre_en;

  assign fetch_req = use_src & ~skip & ~(is_last & nofin_en);
  wire   act       = step & use_src & ~skip;
  wire [W-1:0] inw = fetch_req ? src_word : '0;

  wire [BW-1:0] nxt = dir_neg ? {inw, sbuf[BW-1:W]} : {sbuf[W-1:0], inw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r <= '0;
      sbuf  <= '0;
    end else begin
      if (cfg_wr) cfg_r <= cfg_data & CFG_MASK;
      if (xfer_start) sbuf <= '0;
      else if (act)   sbuf <= nxt;
    end
  end

  assign cfg_q = cfg_r;
  assign win   = W'(sbuf >> sk);

  assert_cfg_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_q == ($past(cfg_data) & CFG_MASK));

  assert_fwd_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fetch_req && !dir_neg && !xfer_start) |=>
      sbuf == {$past(sbuf[W-1:0]), $past(src_word)});

  assert_bwd_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fetch_req && dir_neg && !xfer_start) |=>
      sbuf == {$past(src_word), $past(sbuf[BW-1:W])});

  assert_prime_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == 2'b01 && !cfg_q[7] && !xfer_start) |=> $stable(sbuf));

  assert_no_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'b10 && cfg_q[6]) |-> !fetch_req);

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> sbuf == '0);

  assert_idle_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && !xfer_start) |=> $stable(sbuf));
endmodule

// File: tb/skew_aligner_bench.sv
module skew_aligner_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, dir_neg = 0, xfer_start = 0, step = 0;
  logic [7:0] cfg_data = 0;
  logic [1:0] mode = 0, kind = 0;
  logic [15:0] src_word = 0;
  logic [7:0] cfg_q;
  logic fetch_req;
  logic [15:0] win;

  int checks = 0, errors = 0;
  longint mb = 0;
  int mcfg = 0;

  always #5 clk = ~clk;

  skew_aligner u_skew_aligner (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .cfg_q(cfg_q),
    .dir_neg(dir_neg), .mode(mode), .xfer_start(xfer_start), .step(step),
    .kind(kind), .src_word(src_word), .fetch_req(fetch_req), .win(win));

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit mfetch(input int md, input int k);
    return md[1] && !(k == 1 && !mcfg[7]) && !(k == 2 && mcfg[6]);
  endfunction

  task automatic cyc(input string tag, input bit st, input bit stp, input int md,
                     input bit dn, input int k, input int w);
    bit f;
    @(negedge clk);
    chk(tag, "win", longint'(win), (mb >> (mcfg & 15)) & 16'hFFFF);
    chk("R1", "cfg_q", longint'(cfg_q), longint'(mcfg));
    xfer_start = st; step = stp; mode = 2'(md); dir_neg = dn; kind = 2'(k);
    src_word = 16'(w);
    #1;
    f = mfetch(md, k);
    chk(tag, "fetch_req", longint'(fetch_req), longint'(f));
    @(posedge clk);
    if (st) mb = 0;
    else if (stp && md[1] && !(k == 1 && !mcfg[7])) begin
      longint nw = f ? longint'(w & 16'hFFFF) : 0;
      if (!dn) mb = ((mb << 16) & 32'hFFFFFFFF) | nw;
      else     mb = (mb >> 16) | (nw << 16);
    end
    @(negedge clk);
    xfer_start = 0; step = 0; kind = 0;
  endtask

  task automatic wcfg(input int d);
    @(negedge clk);
    cfg_wr = 1; cfg_data = 8'(d);
    @(posedge clk);
    mcfg = d & 8'hCF;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R10", "win", longint'(win), 0);
    chk("R10", "cfg_q", longint'(cfg_q), 0);
    chk("R10", "fetch_req", longint'(fetch_req), 0);
    rst_n = 1;
    wcfg(8'hFF);
    chk("R1", "cfg_q masked", longint'(cfg_q), 8'hCF);
    // forward, prime on, skew 4
    wcfg(8'h84);
    cyc("R8", 1, 0, 2, 0, 0, 0);
    cyc("R5", 0, 1, 2, 0, 1, 16'hA1B2);
    cyc("R3", 0, 1, 2, 0, 0, 16'hC3D4);
    cyc("R2", 0, 1, 2, 0, 3, 16'hE5F6);
    cyc("R3", 0, 1, 3, 0, 2, 16'h0718);
    // next line without restart keeps contents
    cyc("R8", 0, 0, 2, 0, 0, 0);
    cyc("R8", 0, 1, 2, 0, 1, 16'h1234);
    // prime off, no-final on, skew 9
    wcfg(8'h49);
    cyc("R6", 0, 1, 2, 0, 1, 16'hFFFF);
    cyc("R3", 0, 1, 2, 0, 0, 16'h5A5A);
    cyc("R7", 0, 1, 2, 0, 2, 16'hBEEF);
    // backward, skew 15
    wcfg(8'hCF);
    cyc("R11", 1, 1, 2, 1, 0, 16'h9999);
    cyc("R5", 0, 1, 2, 1, 1, 16'h8001);
    cyc("R4", 0, 1, 2, 1, 0, 16'h4C2E);
    cyc("R4", 0, 1, 3, 1, 0, 16'h7F31);
    cyc("R7", 0, 1, 2, 1, 2, 16'h6666);
    // idle modes
    cyc("R9", 0, 1, 0, 0, 0, 16'h1111);
    cyc("R9", 0, 1, 1, 1, 1, 16'h2222);
    cyc("R9", 0, 1, 1, 0, 2, 16'h3333);
    // skew sweep on a fresh transfer
    wcfg(8'h00);
    cyc("R8", 1, 0, 2, 0, 0, 0);
    cyc("R3", 0, 1, 2, 0, 0, 16'hF00D);
    cyc("R3", 0, 1, 2, 0, 0, 16'h3C96);
    for (int s = 0; s < 16; s++) begin
      wcfg(s);
      cyc("R2", 0, 0, 2, 0, 0, 0);
    end
    wcfg(8'h30);
    chk("R1", "cfg_q bits 5:4", longint'(cfg_q), 0);
    cyc("R2", 0, 0, 2, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule